// File: doc/BRIEF.md
# Five-Stage In-Order Pipelined Processor Core

This block is a compact in-order processor core split into five stages: fetch, decode with operand read, execute, memory access and write-back. Instructions come in on a dedicated instruction port, and loads and stores use a separate data port. The core has a sixteen-entry general register file. After fetch, each stage holds its own copy of the instruction word, and that copy drives the stage's control decisions.

Decode does not wait for the opcode to decide what to read. It always captures both source registers, the register named by the destination field, the instruction's address and the sign-extended constant. Execute therefore always has every operand it could need. The destination register's value travels down the pipe and is used as store data and as the branch condition. The core has no interlocks and no bypass paths. The program must space dependent instructions apart and fill the slots after a branch with NOPs.

Reset is asynchronous and active low. Its deassertion must be synchronous to `clk`. The instruction memory and the data memory are combinational reads that live outside the block.

Top module: `pipe5_core`

## Requirements
- R1: While `rst_n` is low, `imem_addr` is 0 and neither `dmem_we` nor `dmem_re` is asserted. Every stage then holds a NOP, and the first fetch after release is from address 0.
- R2: Each instruction moves one stage per clock. A register result is written at the end of its fifth cycle. Decode reads the register file with no bypass: a reader three slots after the writer gets the old value, and a reader four or more slots after gets the new one.
- R3: The instruction word has opcode [31:28], rd [27:24], rs1 [23:20], rs2 [19:16] and imm [15:0], and imm is sign-extended. The opcodes are 0 NOP, 1 ADD, 2 SUB, 3 AND, 4 OR, 5 XOR, 6 ADDI, 7 LDR, 8 STR and 9 BEQZ. Opcodes 10 to 15 are undefined.
- R4: When no branch is taken, the next fetch address is the current one plus 4.
- R5: BEQZ is taken when the value of rd is zero. The target is the branch address + 4 + (sext(imm) << 2), and it is decided in the memory stage, so the three instructions after the branch still execute. Targets may lie before or after the branch.
- R6: ADD, SUB, AND, OR and XOR write rs1 op rs2 into rd, with results taken modulo 2^32.
- R7: ADDI writes rs1 + sext(imm) into rd.
- R8: LDR drives `dmem_addr` = rs1 + sext(imm) and raises `dmem_re` in its memory cycle. The word read is written into rd.
- R9: STR drives `dmem_addr` = rs1 + sext(imm), puts the value of rd on `dmem_wdata` and raises `dmem_we` for one cycle.
- R10: A NOP, meaning any word with opcode 0, and any undefined opcode write no register and make no data access.
- R11: `dmem_we` and `dmem_re` are never high in the same cycle. Each one is high only for a store or a load, respectively, in the memory stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | XLEN | Fetch address (program counter) |
| imem_rdata | input | 32 | Instruction word for `imem_addr` |
| dmem_addr | output | XLEN | Data access byte address |
| dmem_re | output | 1 | Load strobe |
| dmem_we | output | 1 | Store strobe |
| dmem_wdata | output | XLEN | Store data |
| dmem_rdata | input | XLEN | Load data for `dmem_addr` |

## Verification
On every cycle, the assertions check the following:
- the fetch address steps by 4 or jumps to the target held in the memory stage;
- instruction words pass from decode to execute unchanged;
- the two data strobes are exclusive and appear only for loads and stores.

The arithmetic results and the load and store data paths can only be shown by the bench's programs. The same holds for the exact no-bypass spacing of dependent instructions, the three slots that execute after a branch, and the fact that undefined opcodes change no register. The bench observes all of these through the order and content of stores on the data port.

// File: rtl/pipe5_pkg.sv
`timescale 1ns/1ps
package pipe5_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned OPC_W   = 4;
  localparam int unsigned RIDX_W  = 4;
  localparam int unsigned IMM_W   = 16;
  localparam int unsigned NREG    = 1 << RIDX_W;

  // Opcode values (R3)
  typedef enum logic [OPC_W-1:0] {
    OPC_NOP  = 4'd0,
    OPC_ADD  = 4'd1,
    OPC_SUB  = 4'd2,
    OPC_AND  = 4'd3,
    OPC_OR   = 4'd4,
    OPC_XOR  = 4'd5,
    OPC_ADDI = 4'd6,
    OPC_LDR  = 4'd7,
    OPC_STR  = 4'd8,
    OPC_BEQZ = 4'd9
  } opc_e;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rs1;
    logic [RIDX_W-1:0] rs2;
    logic [IMM_W-1:0]  imm;
  } instr_t;

  // True for opcodes whose result lands in the register file (R10).
  function automatic logic op_writes_rf(logic [OPC_W-1:0] opc);
    logic w;
    case (opc)
      OPC_ADD, OPC_SUB, OPC_AND, OPC_OR, OPC_XOR,
      OPC_ADDI, OPC_LDR: w = 1'b1;
      default:           w = 1'b0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/pipe5_regfile.sv
`timescale 1ns/1ps
module pipe5_regfile #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 16,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic [AW-1:0]   rd_idx_a,
  input  logic [AW-1:0]   rd_idx_b,
  input  logic [AW-1:0]   rd_idx_c,
  output logic [XLEN-1:0] rd_data_a,
  output logic [XLEN-1:0] rd_data_b,
  output logic [XLEN-1:0] rd_data_c
);
  logic [NREG-1:0]           row_en;
  logic [NREG-1:0][XLEN-1:0] rows;

  always_comb begin
    row_en = '0;
    if (wr_en) row_en[wr_idx] = 1'b1;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_row
    logic [XLEN-1:0] row_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         row_q <= '0;
      else if (row_en[g]) row_q <= wr_data;
    end
    assign rows[g] = row_q;
  end

  // Plain reads: a write lands at the clock edge, no internal bypass (R2)
  assign rd_data_a = rows[rd_idx_a];
  assign rd_data_b = rows[rd_idx_b];
  assign rd_data_c = rows[rd_idx_c];
endmodule

// File: rtl/pipe5_alu.sv
`timescale 1ns/1ps
module pipe5_alu
  import pipe5_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [OPC_W-1:0] opc,
  input  logic [XLEN-1:0]  src_a,
  input  logic [XLEN-1:0]  src_b,
  input  logic [XLEN-1:0]  imm_x,
  input  logic [XLEN-1:0]  pc,
  output logic [XLEN-1:0]  result
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_W / 8);

  always_comb begin
    case (opc)
      OPC_ADD:                    result = src_a + src_b;
      OPC_SUB:                    result = src_a - src_b;
      OPC_AND:                    result = src_a & src_b;
      OPC_OR:                     result = src_a | src_b;
      OPC_XOR:                    result = src_a ^ src_b;
      OPC_ADDI, OPC_LDR, OPC_STR: result = src_a + imm_x;
      OPC_BEQZ:                   result = pc + STEP + (imm_x << 2);
      default:                    result = '0;
    endcase
  end
endmodule

// File: rtl/pipe5_brsel.sv
`timescale 1ns/1ps
module pipe5_brsel
  import pipe5_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [OPC_W-1:0] opc,
  input  logic [XLEN-1:0]  cond_val,
  output logic             take
);
  always_comb take = (opc == OPC_BEQZ) && (cond_val == '0);
endmodule

// File: rtl/pipe5_core.sv
`timescale 1ns/1ps
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [XLEN-1:0]    imem_addr,
  input  logic [INSTR_W-1:0] imem_rdata,
  output logic [XLEN-1:0]    dmem_addr,
  output logic               dmem_re,
  output logic               dmem_we,
  output logic [XLEN-1:0]    dmem_wdata,
  input  logic [XLEN-1:0]    dmem_rdata
);
  localparam int unsigned     IMM_PAD = XLEN - IMM_W;
  localparam logic [XLEN-1:0] PC_STEP = XLEN'(INSTR_W / 8);

  // ---------------- stage state ----------------
  logic [XLEN-1:0] pc_q, pc_d;
  instr_t          ir_id_q, ir_id_d;
  logic [XLEN-1:0] pc_id_q, pc_id_d;
  instr_t          ir_ex_q, ir_ex_d;
  logic [XLEN-1:0] pc_ex_q, pc_ex_d;
  logic [XLEN-1:0] s1_ex_q, s1_ex_d;
  logic [XLEN-1:0] s2_ex_q, s2_ex_d;
  logic [XLEN-1:0] dv_ex_q, dv_ex_d;
  logic [XLEN-1:0] imx_ex_q, imx_ex_d;
  instr_t          ir_mem_q, ir_mem_d;
  logic [XLEN-1:0] aluo_mem_q, aluo_mem_d;
  logic [XLEN-1:0] dadr_mem_q, dadr_mem_d;
  logic [XLEN-1:0] sdat_mem_q, sdat_mem_d;
  instr_t          ir_wb_q, ir_wb_d;
  logic [XLEN-1:0] aluo_wb_q, aluo_wb_d;
  logic [XLEN-1:0] lmd_wb_q, lmd_wb_d;
  logic            lmd_en;

  logic [XLEN-1:0] rf_a, rf_b, rf_c;
  logic [XLEN-1:0] alu_res;
  logic            br_take;
  logic            rf_we;
  logic [XLEN-1:0] rf_wdata;

  // ---------------- IF ----------------
  assign imem_addr = pc_q;

  always_comb begin
    pc_d    = br_take ? dadr_mem_q : pc_q + PC_STEP;
    ir_id_d = instr_t'(imem_rdata);
    pc_id_d = pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      ir_id_q <= '0;
      pc_id_q <= '0;
    end else begin
      pc_q    <= pc_d;
      ir_id_q <= ir_id_d;
      pc_id_q <= pc_id_d;
    end
  end

  // ---------------- ID ----------------
  pipe5_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (rf_we),
    .wr_idx    (ir_wb_q.rd),
    .wr_data   (rf_wdata),
    .rd_idx_a  (ir_id_q.rs1),
    .rd_idx_b  (ir_id_q.rs2),
    .rd_idx_c  (ir_id_q.rd),
    .rd_data_a (rf_a),
    .rd_data_b (rf_b),
    .rd_data_c (rf_c)
  );

  always_comb begin
    ir_ex_d  = ir_id_q;
    pc_ex_d  = pc_id_q;
    s1_ex_d  = rf_a;
    s2_ex_d  = rf_b;
    dv_ex_d  = rf_c;
    imx_ex_d = {{IMM_PAD{ir_id_q.imm[IMM_W-1]}}, ir_id_q.imm};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_ex_q  <= '0;
      pc_ex_q  <= '0;
      s1_ex_q  <= '0;
      s2_ex_q  <= '0;
      dv_ex_q  <= '0;
      imx_ex_q <= '0;
    end else begin
      ir_ex_q  <= ir_ex_d;
      pc_ex_q  <= pc_ex_d;
      s1_ex_q  <= s1_ex_d;
      s2_ex_q  <= s2_ex_d;
      dv_ex_q  <= dv_ex_d;
      imx_ex_q <= imx_ex_d;
    end
  end

  // ---------------- EX ----------------
  pipe5_alu #(.XLEN(XLEN)) u_alu (
    .opc    (ir_ex_q.opc),
    .src_a  (s1_ex_q),
    .src_b  (s2_ex_q),
    .imm_x  (imx_ex_q),
    .pc     (pc_ex_q),
    .result (alu_res)
  );

  always_comb begin
    ir_mem_d   = ir_ex_q;
    aluo_mem_d = alu_res;
    dadr_mem_d = alu_res;
    sdat_mem_d = dv_ex_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_mem_q   <= '0;
      aluo_mem_q <= '0;
      dadr_mem_q <= '0;
      sdat_mem_q <= '0;
    end else begin
      ir_mem_q   <= ir_mem_d;
      aluo_mem_q <= aluo_mem_d;
      dadr_mem_q <= dadr_mem_d;
      sdat_mem_q <= sdat_mem_d;
    end
  end

  // ---------------- MEM ----------------
  pipe5_brsel #(.XLEN(XLEN)) u_brsel (
    .opc      (ir_mem_q.opc),
    .cond_val (sdat_mem_q),
    .take     (br_take)
  );

  assign dmem_addr  = dadr_mem_q;
  assign dmem_wdata = sdat_mem_q;
  assign dmem_re    = (ir_mem_q.opc == OPC_LDR);
  assign dmem_we    = (ir_mem_q.opc == OPC_STR);

  always_comb begin
    ir_wb_d   = ir_mem_q;
    aluo_wb_d = aluo_mem_q;
    lmd_wb_d  = dmem_rdata;
    lmd_en    = dmem_re;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_wb_q   <= '0;
      aluo_wb_q <= '0;
      lmd_wb_q  <= '0;
    end else begin
      ir_wb_q   <= ir_wb_d;
      aluo_wb_q <= aluo_wb_d;
      if (lmd_en) lmd_wb_q <= lmd_wb_d;
    end
  end

  // ---------------- WB ----------------
  always_comb begin
    rf_we    = op_writes_rf(ir_wb_q.opc);
    rf_wdata = (ir_wb_q.opc == OPC_LDR) ? lmd_wb_q : aluo_wb_q;
  end
endmodule

// File: rtl/pipe5_core_chk.sv
`timescale 1ns/1ps
module pipe5_core_chk
  import pipe5_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [XLEN-1:0]    imem_addr,
  input logic               dmem_we,
  input logic               dmem_re,
  input logic               br_take,
  input logic [XLEN-1:0]    br_target,
  input logic [INSTR_W-1:0] ir_id,
  input logic [INSTR_W-1:0] ir_ex,
  input logic [INSTR_W-1:0] ir_mem
);
  localparam int unsigned OPC_LSB = INSTR_W - OPC_W;

  // R4: sequential fetch advances by one word
  a_r4_seq_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    !br_take |=> imem_addr == $past(imem_addr) + XLEN'(4));

  // R5: a taken branch redirects fetch to the target held in MEM
  a_r5_branch_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    br_take |=> imem_addr == $past(br_target));

  // R2: decode's word moves into execute on the next clock
  a_r2_id_to_ex: assert property (@(posedge clk) disable iff (!rst_n)
    ir_ex == $past(ir_id));

  // R11: load and store strobes never coincide
  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmem_we && dmem_re));

  // R10: anything but a load or store in MEM leaves the data port idle
  a_r10_quiet_port: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_mem[INSTR_W-1:OPC_LSB] != OPC_LDR && ir_mem[INSTR_W-1:OPC_LSB] != OPC_STR)
      |-> (!dmem_we && !dmem_re));
endmodule

bind pipe5_core pipe5_core_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .imem_addr (imem_addr),
  .dmem_we   (dmem_we),
  .dmem_re   (dmem_re),
  .br_take   (br_take),
  .br_target (dadr_mem_q),
  .ir_id     (ir_id_q),
  .ir_ex     (ir_ex_q),
  .ir_mem    (ir_mem_q)
);

// File: tb/pipe5_core_bench.sv
`timescale 1ns/1ps
module pipe5_core_bench;
  localparam logic [3:0] K_NOP = 4'd0, K_ADD = 4'd1, K_SUB = 4'd2, K_AND = 4'd3,
                         K_OR = 4'd4, K_XOR = 4'd5, K_ADDI = 4'd6, K_LDR = 4'd7,
                         K_STR = 4'd8, K_BEQZ = 4'd9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, dmem_re;

  always #4 clk = ~clk;

  logic [31:0] imem [64];
  logic [31:0] dinit [256];
  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dinit[dmem_addr[9:2]];

  pipe5_core u_pipe5_core (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_re(dmem_re), .dmem_we(dmem_we),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata)
  );

  // Data-port monitor: store log, load count, strobe collisions
  logic [31:0] log_a [16];
  logic [31:0] log_d [16];
  logic [4:0]  st_cnt, re_cnt, both_cnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      st_cnt <= '0; re_cnt <= '0; both_cnt <= '0;
    end else begin
      if (dmem_we) begin
        log_a[st_cnt[3:0]] <= dmem_addr;
        log_d[st_cnt[3:0]] <= dmem_wdata;
        st_cnt <= st_cnt + 5'd1;
      end
      if (dmem_re) re_cnt <= re_cnt + 5'd1;
      if (dmem_we && dmem_re) both_cnt <= both_cnt + 5'd1;
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  int wp = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(logic [3:0] op, logic [3:0] rd, logic [3:0] rs1,
                                      logic [3:0] rs2, logic [15:0] imm);
    return {op, rd, rs1, rs2, imm};
  endfunction

  function automatic logic [31:0] sx(logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] ref_alu(logic [3:0] op, logic [31:0] a, logic [31:0] b);
    case (op)
      K_ADD:   return a + b;
      K_SUB:   return a - b;
      K_AND:   return a & b;
      K_OR:    return a | b;
      default: return a ^ b;
    endcase
  endfunction

  task automatic put(input logic [31:0] w);
    imem[6'(wp)] = w;
    wp++;
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) put(32'h0);
  endtask

  // Enter reset and clear both memories
  task automatic begin_test();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) imem[i] = 32'h0;
    for (int i = 0; i < 256; i++) dinit[i] = 32'h0;
    wp = 0;
  endtask

  task automatic release_run(input int n);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] va [8];
  logic [31:0] vb [8];
  logic [31:0] base [4];
  logic [15:0] imms [4];
  logic [31:0] cvals [4];
  logic [3:0]  ops [5];

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    va[0] = 32'h0;        vb[0] = 32'h0;
    va[1] = 32'h1;        vb[1] = 32'h1;
    va[2] = 32'hFFFFFFFF; vb[2] = 32'h1;
    va[3] = 32'h80000000; vb[3] = 32'h80000000;
    va[4] = 32'h7FFFFFFF; vb[4] = 32'h1;
    va[5] = 32'h12345678; vb[5] = 32'h0F0F0F0F;
    va[6] = 32'h0;        vb[6] = 32'h1;
    va[7] = 32'hA5A5A5A5; vb[7] = 32'h5A5A5A5A;
    base[0] = 32'h0; base[1] = 32'h5; base[2] = 32'hFFFFFFFF; base[3] = 32'h7FFF0000;
    imms[0] = 16'h0000; imms[1] = 16'h7FFF; imms[2] = 16'h8000; imms[3] = 16'hFFFF;
    cvals[0] = 32'h0; cvals[1] = 32'h1; cvals[2] = 32'h80000000; cvals[3] = 32'hFFFFFFFF;
    ops[0] = K_ADD; ops[1] = K_SUB; ops[2] = K_AND; ops[3] = K_OR; ops[4] = K_XOR;

    // R1, R2, R4: reset state, fetch stepping, no-bypass spacing
    begin_test();
    put(enc(K_ADDI, 4'd1, 4'd0, 4'd0, 16'd5));
    nops(2);
    put(enc(K_STR, 4'd1, 4'd0, 4'd0, 16'h0200)); // three slots after: old value
    put(enc(K_STR, 4'd1, 4'd0, 4'd0, 16'h0204)); // four slots after: new value
    repeat (2) @(negedge clk);
    check("R1 reset fetch address", imem_addr, 32'h0);
    check("R1 reset store strobe", {31'd0, dmem_we}, 32'd0);
    check("R1 reset load strobe", {31'd0, dmem_re}, 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      check("R4 sequential fetch", imem_addr, 32'(4 * i));
      @(negedge clk);
    end
    repeat (30) @(negedge clk);
    check("R2 store count", {27'd0, st_cnt}, 32'd2);
    check("R2 reader three slots after sees old value", log_d[0], 32'd0);
    check("R2 reader four slots after sees new value", log_d[1], 32'd5);
    check("R9 store address", log_a[1], 32'h204);

    // R6 + R8: register ALU sweep, operands loaded from data memory
    for (int o = 0; o < 5; o++) begin
      for (int k = 0; k < 8; k++) begin
        logic [3:0] ra, rb, rd;
        ra = 4'(k + 1);
        rb = 4'(9 + (k % 4));
        rd = 4'(13 + ((k + o) % 3));
        begin_test();
        dinit[64] = va[k];
        dinit[65] = vb[k];
        put(enc(K_LDR, ra, 4'd0, 4'd0, 16'h0100));
        put(enc(K_LDR, rb, 4'd0, 4'd0, 16'h0104));
        nops(3);
        put(enc(ops[o], rd, ra, rb, 16'h0));
        nops(3);
        put(enc(K_STR, rd, 4'd0, 4'd0, 16'h0200));
        release_run(40);
        check("R6 store count", {27'd0, st_cnt}, 32'd1);
        check("R8 load count", {27'd0, re_cnt}, 32'd2);
        check("R6 alu result", log_d[0], ref_alu(ops[o], va[k], vb[k]));
        check("R11 no strobe collision", {27'd0, both_cnt}, 32'd0);
      end
    end

    // R7: ADDI with sign-extended constants
    for (int b = 0; b < 4; b++) begin
      for (int m = 0; m < 4; m++) begin
        begin_test();
        dinit[64] = base[b];
        put(enc(K_LDR, 4'd2, 4'd0, 4'd0, 16'h0100));
        nops(3);
        put(enc(K_ADDI, 4'd4, 4'd2, 4'd0, imms[m]));
        nops(3);
        put(enc(K_STR, 4'd4, 4'd0, 4'd0, 16'h0200));
        release_run(40);
        check("R7 addi result", log_d[0], base[b] + sx(imms[m]));
      end
    end

    // R8 + R9: negative load offset, positive store offset from a pointer
    begin_test();
    dinit[64] = 32'h140;
    dinit[79] = 32'hCAFEF00D;
    put(enc(K_LDR, 4'd1, 4'd0, 4'd0, 16'h0100));
    nops(3);
    put(enc(K_LDR, 4'd2, 4'd1, 4'd0, 16'hFFFC));
    nops(3);
    put(enc(K_STR, 4'd2, 4'd1, 4'd0, 16'h0008));
    release_run(40);
    check("R9 store address from pointer", log_a[0], 32'h148);
    check("R8 loaded word via negative offset", log_d[0], 32'hCAFEF00D);

    // R5: forward BEQZ, condition swept, three slots always execute
    for (int c = 0; c < 4; c++) begin
      begin_test();
      dinit[64] = cvals[c];
      put(enc(K_LDR, 4'd1, 4'd0, 4'd0, 16'h0100));
      nops(3);
      put(enc(K_BEQZ, 4'd1, 4'd0, 4'd0, 16'd4));      // byte 16 -> 36
      put(enc(K_ADDI, 4'd6, 4'd0, 4'd0, 16'd7));      // slot 1
      nops(2);
      put(enc(K_ADDI, 4'd5, 4'd0, 4'd0, 16'd1));      // skipped when taken
      put(enc(K_ADDI, 4'd7, 4'd0, 4'd0, 16'd9));      // target
      nops(3);
      put(enc(K_STR, 4'd5, 4'd0, 4'd0, 16'h0200));
      put(enc(K_STR, 4'd6, 4'd0, 4'd0, 16'h0204));
      put(enc(K_STR, 4'd7, 4'd0, 4'd0, 16'h0208));
      release_run(45);
      check("R5 store count", {27'd0, st_cnt}, 32'd3);
      check("R5 fall-through taken only if nonzero", log_d[0], (cvals[c] == 32'h0) ? 32'd0 : 32'd1);
      check("R5 delay slot executes", log_d[1], 32'd7);
      check("R5 target executes", log_d[2], 32'd9);
    end

    // R5: forward then backward branch, loop exit on nonzero
    begin_test();
    put(enc(K_BEQZ, 4'd0, 4'd0, 4'd0, 16'd11));        // 0 -> 48
    nops(3);
    put(enc(K_ADDI, 4'd1, 4'd0, 4'd0, 16'd5));         // 16
    nops(3);
    put(enc(K_ADDI, 4'd5, 4'd0, 4'd0, 16'd3));         // 32
    nops(3);
    put(enc(K_BEQZ, 4'd1, 4'd0, 4'd0, 16'hFFF7));      // 48 -> 16 when r1 == 0
    nops(3);
    put(enc(K_STR, 4'd5, 4'd0, 4'd0, 16'h0200));
    put(enc(K_STR, 4'd1, 4'd0, 4'd0, 16'h0204));
    release_run(45);
    check("R5 backward branch store count", {27'd0, st_cnt}, 32'd2);
    check("R5 backward target reached", log_d[0], 32'd3);
    check("R5 loop exit value", log_d[1], 32'd5);

    // R10: NOP with fields and undefined opcodes leave r1 and the port alone
    begin_test();
    put(enc(K_NOP, 4'd1, 4'd0, 4'd0, 16'h0200));
    for (int u = 10; u < 16; u++) put(enc(4'(u), 4'd1, 4'd0, 4'd0, 16'h0200));
    nops(3);
    put(enc(K_STR, 4'd1, 4'd0, 4'd0, 16'h0204));
    release_run(40);
    check("R10 store count", {27'd0, st_cnt}, 32'd1);
    check("R10 load count", {27'd0, re_cnt}, 32'd0);
    check("R10 register untouched", log_d[0], 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule